// File: doc/BRIEF.md
# Packed Vector Attribute Loader

This block takes a stream of 32-bit data writes. Every three writes carry one four-component vector, and each component is a 24-bit floating-point value held as raw bits. The block collects the three words and splits them into the components x, y, z and w. A setup index then decides where the vector goes. An index from 0 to 14 writes the vector into a default-attribute table of fifteen entries and moves the index up by one. An index of exactly 15 places the vector in the current slot of an immediate-mode vertex buffer. Any index of 16 or more throws the vector away and sets a sticky error flag.

In immediate mode the block fills slots from 0 up to a configured last-slot index. When the last slot is stored, it offers the whole vertex on a valid/ready output. It holds that output stable, and it refuses data writes until the vertex is taken. The block does no arithmetic on the values.

Two state machines drive the block. The word gatherer has states `GATHER_W0`, `GATHER_W1` and `GATHER_W2`. Each accepted write moves it one step forward, and the write accepted in `GATHER_W2` completes a vector and returns it to `GATHER_W0`. The immediate assembler has states `IMM_FILL` and `IMM_OFFER`. Storing the last slot moves it from `IMM_FILL` to `IMM_OFFER`, and an accepted handshake moves it from `IMM_OFFER` back to `IMM_FILL`.

Top module: `packed_attr_loader`

## Requirements
- R1: After reset the word counter is at the first word, `cur_index` is 0, `err_flag` is 0, `vtx_valid` is 0, `wr_ready` is 1, and every table entry reads as zero.
- R2: A vector completes only on the third accepted data write. After one or two words, neither the table nor the index changes.
- R3: For words a, b and c in arrival order, the components are unpacked as follows:
  - w = a[31:8]
  - z = {a[7:0], b[31:16]}
  - y = {b[15:0], c[31:24]}
  - x = c[23:0]
- R4: A 96-bit vector is laid out as {w, z, y, x}, with x in bits 23:0.
- R5: A completed vector with `cur_index` below 15 is written into table entry `cur_index`, and `cur_index` then increases by one.
- R6: A pulse on `idx_load` loads `idx_value` into `cur_index`. If it coincides with a completing vector, the vector is routed by the old index and the loaded value wins over the increment.
- R7: A completed vector with `cur_index` of 16 or more is discarded. The table and `cur_index` stay unchanged, and `err_flag` becomes 1.
- R8: `err_flag` stays set until `err_clear` is pulsed. If a new error and the clear happen in the same cycle, the flag stays set.
- R9: A completed vector with `cur_index` equal to 15 is stored in the current immediate slot, and `cur_index` stays 15. If the slot is below `last_slot`, the slot advances by one.
- R10: Storing into slot `last_slot` resets the slot to 0 and raises `vtx_valid` on the next cycle. `vtx_data` then carries slot k in bits [k*96 +: 96].
- R11: While `vtx_valid` is high and `vtx_ready` is low, `vtx_data` stays stable, `wr_ready` is 0, and data writes are ignored. A cycle with both `vtx_valid` and `vtx_ready` high drops `vtx_valid` and restores `wr_ready` on the next cycle.
- R12: With `last_slot` set to 0, every immediate vector is emitted as a one-slot vertex.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | 32 | Packed data word |
| wr_ready | output | 1 | Data writes accepted this cycle |
| idx_load | input | 1 | Load the setup index |
| idx_value | input | 5 | New setup index |
| cur_index | output | 5 | Present setup index |
| last_slot | input | 3 | Last immediate slot index |
| rd_addr | input | 4 | Table read address |
| rd_data | output | 96 | Table entry {w,z,y,x} |
| vtx_valid | output | 1 | Vertex offered |
| vtx_ready | input | 1 | Vertex taken |
| vtx_data | output | 768 | Eight slots of {w,z,y,x} |
| err_flag | output | 1 | Sticky out-of-range error |
| err_clear | input | 1 | Clears the error flag |

## Verification
The assertions check several rules on every cycle:
- The index steps by one after each vector written to the table.
- The index holds after a discarded vector.
- The error flag stays set.
- The offered vertex stays stable under back-pressure.
- Two vectors never complete on back-to-back cycles.
- Data writes are blocked while a vertex is offered.

Only the bench scenarios can show the rest. Those are the bit placement of the unpacked components, the index-load priority, the exact slot layout of the emitted vertex, and that a write made during a stall leaves the word alignment intact.

// File: rtl/pva_pkg.sv
package pva_pkg;

    localparam int COMP_W = 24;
    localparam int WORD_W = 32;
    localparam int VEC_W  = 4 * COMP_W;

    typedef struct packed {
        logic [COMP_W-1:0] w;
        logic [COMP_W-1:0] z;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] x;
    } attr_vec_t;

    typedef enum logic [1:0] {
        GATHER_W0 = 2'd0,
        GATHER_W1 = 2'd1,
        GATHER_W2 = 2'd2
    } gather_state_t;

    typedef enum logic {
        IMM_FILL  = 1'b0,
        IMM_OFFER = 1'b1
    } imm_state_t;

    typedef enum logic [1:0] {
        ROUTE_TABLE = 2'd0,
        ROUTE_IMM   = 2'd1,
        ROUTE_DROP  = 2'd2
    } route_t;

    // Three packed words -> four components; word a holds the top of w.
    function automatic attr_vec_t unpack_words(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic [WORD_W-1:0] c);
        attr_vec_t v;
        v.w = a[31:8];
        v.z = {a[7:0], b[31:16]};
        v.y = {b[15:0], c[31:24]};
        v.x = c[23:0];
        return v;
    endfunction

endpackage

// File: rtl/pva_word_gather.sv
module pva_word_gather
    import pva_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    output logic              vec_done,
    output attr_vec_t         vec
);

    gather_state_t state, state_nx;
    logic [WORD_W-1:0] hold_a, hold_b;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATHER_W0;
        else if (take) state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GATHER_W0: state_nx = GATHER_W1;
            GATHER_W1: state_nx = GATHER_W2;
            GATHER_W2: state_nx = GATHER_W0;
            default:   state_nx = GATHER_W0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_a <= '0;
            hold_b <= '0;
        end else if (take) begin
            if (state == GATHER_W0) hold_a <= word;
            if (state == GATHER_W1) hold_b <= word;
        end
    end

    always_comb begin
        vec_done = take && (state == GATHER_W2);
        vec      = unpack_words(hold_a, hold_b, word);
    end

    // R2: a completion needs three accepted words, so never two in a row
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |=> !vec_done);

endmodule

// File: rtl/pva_default_table.sv
module pva_default_table
    import pva_pkg::*;
#(
    parameter int DEPTH  = 15,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  attr_vec_t         wr_vec,
    input  logic [ADDR_W-1:0] rd_addr,
    output attr_vec_t         rd_vec
);

    attr_vec_t entry [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) entry[e] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(e))) entry[e] <= wr_vec;
        end
    end

    always_comb begin
        rd_vec = '0;
        for (int e = 0; e < DEPTH; e++)
            if (rd_addr == ADDR_W'(e)) rd_vec = entry[e];
    end

endmodule

// File: rtl/pva_imm_assembler.sv
module pva_imm_assembler
    import pva_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   store,
    input  attr_vec_t              vec,
    input  logic [SLOT_W-1:0]      last_slot,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [SLOTS*VEC_W-1:0] out_data,
    output logic                   accept
);

    imm_state_t state, state_nx;
    logic [SLOT_W-1:0] slot;
    attr_vec_t slot_q [SLOTS];
    logic final_store;

    assign final_store = store && (slot >= last_slot);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IMM_FILL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IMM_FILL:  if (final_store) state_nx = IMM_OFFER;
            IMM_OFFER: if (out_ready)   state_nx = IMM_FILL;
            default:   state_nx = IMM_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           slot <= '0;
        else if (final_store) slot <= '0;
        else if (store)       slot <= slot + 1'b1;
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[s] <= '0;
            else if (store && (slot == SLOT_W'(s))) slot_q[s] <= vec;
        end
        assign out_data[s*VEC_W +: VEC_W] = slot_q[s];
    end

    always_comb begin
        out_valid = (state == IMM_OFFER);
        accept    = (state == IMM_FILL);
    end

    // R11: offered vertex held stable under back-pressure
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R10: a vertex is offered only after a final slot was stored
    a_r10_offer_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(store));

endmodule

// File: rtl/packed_attr_loader.sv
module packed_attr_loader
    import pva_pkg::*;
#(
    parameter int TABLE_DEPTH = 15,
    parameter int IDX_W       = 5,
    parameter int SLOTS       = 8,
    parameter int SLOT_W      = $clog2(SLOTS),
    parameter int ADDR_W      = $clog2(TABLE_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [31:0]            wr_data,
    output logic                   wr_ready,
    input  logic                   idx_load,
    input  logic [IDX_W-1:0]       idx_value,
    output logic [IDX_W-1:0]       cur_index,
    input  logic [SLOT_W-1:0]      last_slot,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [95:0]            rd_data,
    output logic                   vtx_valid,
    input  logic                   vtx_ready,
    output logic [SLOTS*96-1:0]    vtx_data,
    output logic                   err_flag,
    input  logic                   err_clear
);

    localparam logic [IDX_W-1:0] IMM_INDEX = IDX_W'(TABLE_DEPTH);

    logic      take, vec_done;
    attr_vec_t vec, rd_vec;
    route_t    route;
    logic [IDX_W-1:0] idx_q;
    logic      err_q;
    logic      imm_accept;

    assign take = wr_valid && imm_accept;

    pva_word_gather u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .word     (wr_data),
        .vec_done (vec_done),
        .vec      (vec)
    );

    always_comb begin
        if (idx_q < IMM_INDEX)       route = ROUTE_TABLE;
        else if (idx_q == IMM_INDEX) route = ROUTE_IMM;
        else                         route = ROUTE_DROP;
    end

    pva_default_table #(.DEPTH(TABLE_DEPTH), .ADDR_W(ADDR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_done && (route == ROUTE_TABLE)),
        .wr_addr (idx_q[ADDR_W-1:0]),
        .wr_vec  (vec),
        .rd_addr (rd_addr),
        .rd_vec  (rd_vec)
    );

    pva_imm_assembler #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_imm (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (vec_done && (route == ROUTE_IMM)),
        .vec       (vec),
        .last_slot (last_slot),
        .out_ready (vtx_ready),
        .out_valid (vtx_valid),
        .out_data  (vtx_data),
        .accept    (imm_accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                idx_q <= '0;
        else if (idx_load)                         idx_q <= idx_value;
        else if (vec_done && route == ROUTE_TABLE) idx_q <= idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                               err_q <= 1'b0;
        else if (vec_done && route == ROUTE_DROP) err_q <= 1'b1;
        else if (err_clear)                       err_q <= 1'b0;
    end

    always_comb begin
        wr_ready  = imm_accept;
        cur_index = idx_q;
        err_flag  = err_q;
        rd_data   = rd_vec;
    end

    // R5: table write advances the index by one
    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_done && cur_index < IMM_INDEX && !idx_load)
        |=> cur_index == $past(cur_index) + 1'b1);
    // R7: discarded vector leaves the index and raises the error
    a_r7_drop_holds_index: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_done && cur_index > IMM_INDEX && !idx_load)
        |=> ($stable(cur_index) && err_flag));
    // R8: error is sticky without a clear
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> err_flag);
    // R9: immediate mode keeps the index at the sentinel
    a_r9_imm_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_done && cur_index == IMM_INDEX && !idx_load) |=> cur_index == IMM_INDEX);
    // R11: writes blocked while a vertex is offered
    a_r11_block_writes: assert property (@(posedge clk) disable iff (!rst_n)
        vtx_valid |-> !wr_ready);

endmodule

// File: tb/packed_attr_loader_test.sv
`timescale 1ns/1ps
module packed_attr_loader_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic wr_ready;
    logic idx_load = 1'b0;
    logic [4:0] idx_value = '0;
    logic [4:0] cur_index;
    logic [2:0] last_slot = '0;
    logic [3:0] rd_addr = '0;
    logic [95:0] rd_data;
    logic vtx_valid;
    logic vtx_ready = 1'b0;
    logic [767:0] vtx_data;
    logic err_flag;
    logic err_clear = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    packed_attr_loader uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .idx_load(idx_load), .idx_value(idx_value),
        .cur_index(cur_index), .last_slot(last_slot), .rd_addr(rd_addr),
        .rd_data(rd_data), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
        .vtx_data(vtx_data), .err_flag(err_flag), .err_clear(err_clear)
    );

    task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Packs components per R3 into three words.
    function automatic logic [95:0] pack3(input logic [23:0] x, input logic [23:0] y,
                                          input logic [23:0] z, input logic [23:0] w);
        logic [31:0] a, b, c;
        a = {w, z[23:16]};
        b = {z[15:0], y[23:8]};
        c = {y[7:0], x};
        return {a, b, c};
    endfunction

    task automatic put_word(input logic [31:0] w, input logic ld, input logic [4:0] lv,
                            input logic clr);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = w; idx_load = ld; idx_value = lv; err_clear = clr;
        @(negedge clk);
        wr_valid = 1'b0; idx_load = 1'b0; err_clear = 1'b0;
    endtask

    task automatic put_vec(input logic [95:0] words);
        put_word(words[95:64], 1'b0, 5'd0, 1'b0);
        put_word(words[63:32], 1'b0, 5'd0, 1'b0);
        put_word(words[31:0],  1'b0, 5'd0, 1'b0);
    endtask

    task automatic load_index(input logic [4:0] v);
        @(negedge clk); idx_load = 1'b1; idx_value = v;
        @(negedge clk); idx_load = 1'b0;
    endtask

    task automatic read_entry(input logic [3:0] a, output logic [95:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic t_reset();
        logic [95:0] v;
        check("R1 index", {91'd0, cur_index}, 96'd0);
        check("R1 err", {95'd0, err_flag}, 96'd0);
        check("R1 vtx_valid", {95'd0, vtx_valid}, 96'd0);
        check("R1 wr_ready", {95'd0, wr_ready}, 96'd1);
        for (int e = 0; e < 15; e++) begin
            read_entry(e[3:0], v);
            check("R1 table zero", v, 96'd0);
        end
    endtask

    task automatic t_table();
        logic [95:0] wa, wb, v;
        wa = pack3(24'h123456, 24'hABCDEF, 24'h0F1E2D, 24'hC0FFEE);
        wb = pack3(24'h000001, 24'h800000, 24'hFFFFFF, 24'h7A5A5A);
        put_word(wa[95:64], 1'b0, 5'd0, 1'b0);
        put_word(wa[63:32], 1'b0, 5'd0, 1'b0);
        read_entry(4'd0, v);
        check("R2 no write after two words", v, 96'd0);
        check("R2 index unchanged", {91'd0, cur_index}, 96'd0);
        put_word(wa[31:0], 1'b0, 5'd0, 1'b0);
        read_entry(4'd0, v);
        check("R3 R4 unpack entry0", v, {24'hC0FFEE, 24'h0F1E2D, 24'hABCDEF, 24'h123456});
        check("R5 index to 1", {91'd0, cur_index}, 96'd1);
        put_vec(wb);
        read_entry(4'd1, v);
        check("R3 unpack entry1", v, {24'h7A5A5A, 24'hFFFFFF, 24'h800000, 24'h000001});
        check("R5 index to 2", {91'd0, cur_index}, 96'd2);
    endtask

    task automatic t_load();
        logic [95:0] wc, wd, v;
        wc = pack3(24'h111111, 24'h222222, 24'h333333, 24'h444444);
        wd = pack3(24'h555555, 24'h666666, 24'h777777, 24'h888888);
        load_index(5'd14);
        check("R6 load", {91'd0, cur_index}, 96'd14);
        put_vec(wc);
        read_entry(4'd14, v);
        check("R5 entry14", v, {24'h444444, 24'h333333, 24'h222222, 24'h111111});
        check("R5 index to 15", {91'd0, cur_index}, 96'd15);
        load_index(5'd3);
        put_word(wd[95:64], 1'b0, 5'd0, 1'b0);
        put_word(wd[63:32], 1'b0, 5'd0, 1'b0);
        put_word(wd[31:0],  1'b1, 5'd7, 1'b0);
        read_entry(4'd3, v);
        check("R6 old index routes", v, {24'h888888, 24'h777777, 24'h666666, 24'h555555});
        check("R6 load beats increment", {91'd0, cur_index}, 96'd7);
    endtask

    task automatic t_error();
        logic [95:0] we, v;
        we = pack3(24'h9, 24'h8, 24'h7, 24'h6);
        load_index(5'd20);
        put_vec(we);
        check("R7 error raised", {95'd0, err_flag}, 96'd1);
        check("R7 index unchanged", {91'd0, cur_index}, 96'd20);
        read_entry(4'd3, v);
        check("R7 table untouched", v, {24'h888888, 24'h777777, 24'h666666, 24'h555555});
        repeat (3) @(negedge clk);
        check("R8 sticky", {95'd0, err_flag}, 96'd1);
        @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        check("R8 cleared", {95'd0, err_flag}, 96'd0);
        put_word(we[95:64], 1'b0, 5'd0, 1'b0);
        put_word(we[63:32], 1'b0, 5'd0, 1'b0);
        put_word(we[31:0],  1'b0, 5'd0, 1'b1);
        check("R8 set wins over clear", {95'd0, err_flag}, 96'd1);
        @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic t_immediate();
        logic [95:0] exp0, exp1, exp2, exp3;
        logic [767:0] snap;
        exp0 = {24'hA00000, 24'hA00001, 24'hA00002, 24'hA00003};
        exp1 = {24'hB00000, 24'hB00001, 24'hB00002, 24'hB00003};
        exp2 = {24'hC00000, 24'hC00001, 24'hC00002, 24'hC00003};
        exp3 = {24'hD0D0D0, 24'hE0E0E0, 24'hF0F0F0, 24'h010203};
        last_slot = 3'd2;
        vtx_ready = 1'b0;
        load_index(5'd15);
        put_vec(pack3(exp0[23:0], exp0[47:24], exp0[71:48], exp0[95:72]));
        put_vec(pack3(exp1[23:0], exp1[47:24], exp1[71:48], exp1[95:72]));
        check("R9 no vertex before last slot", {95'd0, vtx_valid}, 96'd0);
        check("R9 index stays 15", {91'd0, cur_index}, 96'd15);
        put_vec(pack3(exp2[23:0], exp2[47:24], exp2[71:48], exp2[95:72]));
        check("R10 vertex offered", {95'd0, vtx_valid}, 96'd1);
        check("R10 slot0", vtx_data[0 +: 96], exp0);
        check("R10 slot1", vtx_data[96 +: 96], exp1);
        check("R10 slot2", vtx_data[192 +: 96], exp2);
        check("R11 writes blocked", {95'd0, wr_ready}, 96'd1 ^ 96'd1);
        snap = vtx_data;
        put_word(32'hDEADBEEF, 1'b0, 5'd0, 1'b0);
        repeat (2) @(negedge clk);
        check("R11 still valid", {95'd0, vtx_valid}, 96'd1);
        check("R11 data stable", {95'd0, (vtx_data === snap)}, 96'd1);
        @(negedge clk); vtx_ready = 1'b1; @(negedge clk); vtx_ready = 1'b0;
        check("R11 valid dropped", {95'd0, vtx_valid}, 96'd0);
        check("R11 writes resumed", {95'd0, wr_ready}, 96'd1);
        last_slot = 3'd0;
        put_vec(pack3(exp3[23:0], exp3[47:24], exp3[71:48], exp3[95:72]));
        check("R12 single-slot vertex", {95'd0, vtx_valid}, 96'd1);
        check("R12 R11 stalled word ignored", vtx_data[0 +: 96], exp3);
        check("R12 slot1 untouched", vtx_data[96 +: 96], exp1);
        @(negedge clk); vtx_ready = 1'b1; @(negedge clk); vtx_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table();
        t_load();
        t_error();
        t_immediate();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule